// File: doc/BRIEF.md
# Concatenable Dual-Channel PWM Pair

This block holds two narrow pulse-width channels, a low channel and a high channel, each with its own counter, period, duty, enable, polarity, alignment and clock-select setting. A merge bit in the control register joins them into one channel of twice the width. The high channel then supplies the upper half of the counter, period and duty, and the low channel supplies the lower half. The merged waveform leaves on the low channel's pin. Every control setting for the merged channel is taken from the low channel's bits, and the high pin is parked at 0.

Each counter advances only on a one-cycle strobe from one of two prescaled clock-enable inputs, A or B, chosen per channel. Left-aligned channels count up and wrap. Center-aligned channels count up to the period and back down. New period and duty values are staged in buffer registers and move into the comparators at the next return of the counter to zero, or at once while the channel is off.

A simple register port reads and writes both halves. Accesses are either one byte (one channel) or wide (both channels at once). In merged mode, counter writes and counter reads follow rules that keep the wide value consistent.

Top module: `pwm_pair_ctl`

## Requirements
- R1: After reset the control register, all counters, periods and duties read 0. Both pins sit at their inactive level, which is 1 because polarity is 0.
- R2: Left-aligned (alignment bit 0): on each selected strobe the counter steps 0,1,..,P-1 and then returns to 0, where P is the period; with P of 0 it stays at 0. The pin equals the polarity bit while counter < duty and its inverse otherwise.
- R3: Center-aligned (alignment bit 1): the counter steps up from 0 to P, then down to 1, then returns to 0, so one cycle is 2*P strobes. The pin follows the same counter < duty rule, so it toggles where the counter crosses the duty value.
- R4: A channel's clock-select bit picks strobe A (0) or strobe B (1). The counter does not move on the other strobe or on cycles with no strobe.
- R5: Period and duty writes go to buffers that read back at once. While the channel runs, the comparators take the buffered values only when the counter returns to 0. While the channel is off, they follow the buffers.
- R6: With its enable bit at 0, a channel's counter holds its value through any strobe, and its pin shows the inverse of its polarity bit.
- R7: With the merge bit set, the counter is {high,low} of twice the width, compared with {high,low} period and duty. The result drives the low pin with the low polarity bit, and the high pin is held at 0.
- R8: With the merge bit set, the high channel's enable, polarity, alignment and clock-select bits have no effect.
- R9: Any write to the counter clears it to 0, whatever the data. In merged mode a byte write to either half or a wide write clears the full counter. In split mode only the addressed channel or channels are cleared.
- R10: A wide counter read returns {high,low} as sampled together in the cycle of the read.
- R11: In merged mode, a byte read of one counter half returns the live half and latches the other half. The next byte read of that other half returns the latched value and clears the latch; without a latch it returns the live value and latches in turn.
- R12: Register select: 0 control, 1 counter, 2 period, 3 duty. Control bits: 0 low enable, 1 high enable, 2 low polarity, 3 high polarity, 4 low alignment, 5 high alignment, 6 low clock-select, 7 high clock-select, 8 merge. A byte access uses data bits [7:0], with the hi flag selecting the channel. A wide access carries {high,low}, and the control register takes data bits [8:0]. Read data appears the cycle after a read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_a | input | 1 | Prescaled clock-enable strobe A |
| tick_b | input | 1 | Prescaled clock-enable strobe B |
| wr_en | input | 1 | Write request |
| wr_sel | input | 2 | Register select for the write |
| wr_wide | input | 1 | Wide (both channels) write |
| wr_hi | input | 1 | Byte write targets the high channel |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Register select for the read |
| rd_wide | input | 1 | Wide (both channels) read |
| rd_hi | input | 1 | Byte read targets the high channel |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| pwm_lo | output | 1 | Low channel pin (merged output) |
| pwm_hi | output | 1 | High channel pin |

## Verification
The assertions assume the inputs are known from the first clock after reset. They also assume a counter only moves in cycles where its selected strobe is high and no counter write is present, so a strobe and a counter write in the same cycle resolve in favour of the write. The stimulus keeps each strobe, write and read to a single cycle and never overlaps a read with a write. It changes period, duty and merge settings with the channel disabled, except in the buffering test, which rewrites them mid-period on purpose.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_PER  = 2'd2,
    REG_DUTY = 2'd3
  } reg_sel_e;

  // packed MSB first: merge is bit 8, en_lo is bit 0
  typedef struct packed {
    logic merge;
    logic csel_hi;
    logic csel_lo;
    logic cae_hi;
    logic cae_lo;
    logic pol_hi;
    logic pol_lo;
    logic en_hi;
    logic en_lo;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_wave_step.sv
// Next-count arithmetic for one counter of width W, left or center aligned.
module pwm_wave_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  logic [W-1:0] per,
  input  logic         center,
  output logic [W-1:0] cnt_nx,
  output logic         up_nx,
  output logic         wrap
);

  // {wrap, next} for a left-aligned counter
  function automatic logic [W:0] left_next(input logic [W-1:0] c, input logic [W-1:0] p);
    if (c >= p - W'(1)) return {1'b1, {W{1'b0}}};
    return {1'b0, c + W'(1)};
  endfunction

  // {wrap, up_next, next} for a center-aligned counter
  function automatic logic [W+1:0] center_next(input logic [W-1:0] c, input logic u,
                                               input logic [W-1:0] p);
    if (c <= W'(1) && (!u || c >= p)) return {2'b11, {W{1'b0}}};
    if (u && c < p)                   return {2'b01, c + W'(1)};
    return {2'b00, c - W'(1)};
  endfunction

  logic [W:0]   l_res;
  logic [W+1:0] c_res;

  assign l_res = left_next(cnt, per);
  assign c_res = center_next(cnt, up, per);

  always_comb begin
    if (per == '0) begin
      cnt_nx = '0;
      up_nx  = 1'b1;
      wrap   = 1'b1;
    end else if (!center) begin
      cnt_nx = l_res[W-1:0];
      up_nx  = 1'b1;
      wrap   = l_res[W];
    end else begin
      cnt_nx = c_res[W-1:0];
      up_nx  = c_res[W];
      wrap   = c_res[W+1];
    end
  end

endmodule

// File: rtl/pwm_rd_port.sv
// Registered read path with the merged-mode byte snapshot rule.
module pwm_rd_port
  import pwm_pair_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  input  logic              rd_wide,
  input  logic              rd_hi,
  input  logic              merge_on,
  input  logic              cnt_wr,
  input  logic [CTRL_W-1:0] ctrl_bits,
  input  logic [CW-1:0]     cnt_lo,
  input  logic [CW-1:0]     cnt_hi,
  input  logic [CW-1:0]     per_lo,
  input  logic [CW-1:0]     per_hi,
  input  logic [CW-1:0]     duty_lo,
  input  logic [CW-1:0]     duty_hi,
  output logic [2*CW-1:0]   rd_data
);

  localparam int DW = 2 * CW;

  function automatic logic [DW-1:0] pick(input logic [CW-1:0] lo, input logic [CW-1:0] hi,
                                         input logic wide, input logic hsel);
    if (wide) return {hi, lo};
    return {{CW{1'b0}}, hsel ? hi : lo};
  endfunction

  logic [CW-1:0] snap_lo, snap_hi;
  logic          vld_lo, vld_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      snap_lo <= '0;
      snap_hi <= '0;
      vld_lo  <= 1'b0;
      vld_hi  <= 1'b0;
    end else begin
      if (rd_en) begin
        case (rd_sel)
          REG_CTRL: rd_data <= DW'(ctrl_bits);
          REG_PER:  rd_data <= pick(per_lo, per_hi, rd_wide, rd_hi);
          REG_DUTY: rd_data <= pick(duty_lo, duty_hi, rd_wide, rd_hi);
          default: begin
            if (merge_on && !rd_wide) begin
              if (rd_hi && vld_hi) begin
                rd_data <= {{CW{1'b0}}, snap_hi};
                vld_hi  <= 1'b0;
              end else if (rd_hi) begin
                rd_data <= {{CW{1'b0}}, cnt_hi};
                snap_lo <= cnt_lo;
                vld_lo  <= 1'b1;
              end else if (vld_lo) begin
                rd_data <= {{CW{1'b0}}, snap_lo};
                vld_lo  <= 1'b0;
              end else begin
                rd_data <= {{CW{1'b0}}, cnt_lo};
                snap_hi <= cnt_hi;
                vld_hi  <= 1'b1;
              end
            end else begin
              rd_data <= pick(cnt_lo, cnt_hi, rd_wide, rd_hi);
              vld_lo  <= 1'b0;
              vld_hi  <= 1'b0;
            end
          end
        endcase
      end
      if (cnt_wr || !merge_on) begin
        vld_lo <= 1'b0;
        vld_hi <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwm_pair_ctl.sv
module pwm_pair_ctl
  import pwm_pair_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_a,
  input  logic            tick_b,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic            wr_wide,
  input  logic            wr_hi,
  input  logic [2*CW-1:0] wr_data,
  input  logic            rd_en,
  input  logic [1:0]      rd_sel,
  input  logic            rd_wide,
  input  logic            rd_hi,
  output logic [2*CW-1:0] rd_data,
  output logic            pwm_lo,
  output logic            pwm_hi
);

  localparam int DW = 2 * CW;

  function automatic logic level(input logic [DW-1:0] c, input logic [DW-1:0] d,
                                 input logic pol, input logic en);
    if (!en) return !pol;
    return (c < d) ? pol : !pol;
  endfunction

  ctrl_t ctrl;
  logic  merge_on, en_lo_b, pol_lo_b, cae_lo_b;
  assign merge_on = ctrl.merge;
  assign en_lo_b  = ctrl.en_lo;
  assign pol_lo_b = ctrl.pol_lo;
  assign cae_lo_b = ctrl.cae_lo;

  logic [CW-1:0] cnt_lo, cnt_hi;
  logic          up_lo, up_hi;
  logic [CW-1:0] per_buf_lo, per_buf_hi, duty_buf_lo, duty_buf_hi;
  logic [CW-1:0] per_act_lo, per_act_hi, duty_act_lo, duty_act_hi;

  // write decode
  logic          we_lo, we_hi, cnt_wr;
  logic [CW-1:0] dat_lo, dat_hi;
  assign we_lo  = wr_en && (wr_wide || !wr_hi);
  assign we_hi  = wr_en && (wr_wide || wr_hi);
  assign dat_lo = wr_data[CW-1:0];
  assign dat_hi = wr_wide ? wr_data[DW-1:CW] : wr_data[CW-1:0];
  assign cnt_wr = wr_en && (wr_sel == REG_CNT);

  // named events
  logic clr_lo, clr_hi, tick_lo, tick_hi;
  logic step_lo, step_hi, step_cat, ld_lo, ld_hi;
  assign clr_lo   = cnt_wr && (merge_on || we_lo);
  assign clr_hi   = cnt_wr && (merge_on || we_hi);
  assign tick_lo  = ctrl.csel_lo ? tick_b : tick_a;
  assign tick_hi  = ctrl.csel_hi ? tick_b : tick_a;
  assign step_lo  = !merge_on && ctrl.en_lo && tick_lo && !clr_lo;
  assign step_hi  = !merge_on && ctrl.en_hi && tick_hi && !clr_hi;
  assign step_cat = merge_on && ctrl.en_lo && tick_lo && !clr_lo;

  logic [CW-1:0] lo_nx, hi_nx;
  logic [DW-1:0] cat_nx;
  logic          lo_up_nx, hi_up_nx, cat_up_nx, lo_wrap, hi_wrap, cat_wrap;

  pwm_wave_step #(.W(CW)) u_step_lo (
    .cnt(cnt_lo), .up(up_lo), .per(per_act_lo), .center(ctrl.cae_lo),
    .cnt_nx(lo_nx), .up_nx(lo_up_nx), .wrap(lo_wrap));

  pwm_wave_step #(.W(CW)) u_step_hi (
    .cnt(cnt_hi), .up(up_hi), .per(per_act_hi), .center(ctrl.cae_hi),
    .cnt_nx(hi_nx), .up_nx(hi_up_nx), .wrap(hi_wrap));

  pwm_wave_step #(.W(DW)) u_step_cat (
    .cnt({cnt_hi, cnt_lo}), .up(up_lo), .per({per_act_hi, per_act_lo}),
    .center(ctrl.cae_lo), .cnt_nx(cat_nx), .up_nx(cat_up_nx), .wrap(cat_wrap));

  logic ld_cat;
  assign ld_cat = !ctrl.en_lo || (step_cat && cat_wrap);
  assign ld_lo  = merge_on ? ld_cat : (!ctrl.en_lo || (step_lo && lo_wrap));
  assign ld_hi  = merge_on ? ld_cat : (!ctrl.en_hi || (step_hi && hi_wrap));

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n)                          ctrl <= '0;
    else if (wr_en && wr_sel == REG_CTRL) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  // low channel state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      up_lo  <= 1'b1;
    end else if (clr_lo) begin
      cnt_lo <= '0;
      up_lo  <= 1'b1;
    end else if (step_cat) begin
      cnt_lo <= cat_nx[CW-1:0];
      up_lo  <= cat_up_nx;
    end else if (step_lo) begin
      cnt_lo <= lo_nx;
      up_lo  <= lo_up_nx;
    end
  end

  // high channel state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_hi <= '0;
      up_hi  <= 1'b1;
    end else if (clr_hi) begin
      cnt_hi <= '0;
      up_hi  <= 1'b1;
    end else if (step_cat) begin
      cnt_hi <= cat_nx[DW-1:CW];
    end else if (step_hi) begin
      cnt_hi <= hi_nx;
      up_hi  <= hi_up_nx;
    end
  end

  // period / duty buffers and active copies
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_buf_lo  <= '0;
      per_buf_hi  <= '0;
      duty_buf_lo <= '0;
      duty_buf_hi <= '0;
      per_act_lo  <= '0;
      per_act_hi  <= '0;
      duty_act_lo <= '0;
      duty_act_hi <= '0;
    end else begin
      if (we_lo && wr_sel == REG_PER)  per_buf_lo  <= dat_lo;
      if (we_hi && wr_sel == REG_PER)  per_buf_hi  <= dat_hi;
      if (we_lo && wr_sel == REG_DUTY) duty_buf_lo <= dat_lo;
      if (we_hi && wr_sel == REG_DUTY) duty_buf_hi <= dat_hi;
      if (ld_lo) begin
        per_act_lo  <= per_buf_lo;
        duty_act_lo <= duty_buf_lo;
      end
      if (ld_hi) begin
        per_act_hi  <= per_buf_hi;
        duty_act_hi <= duty_buf_hi;
      end
    end
  end

  // pins
  always_comb begin
    if (merge_on) begin
      pwm_lo = level({cnt_hi, cnt_lo}, {duty_act_hi, duty_act_lo}, ctrl.pol_lo, ctrl.en_lo);
      pwm_hi = 1'b0;
    end else begin
      pwm_lo = level({{CW{1'b0}}, cnt_lo}, {{CW{1'b0}}, duty_act_lo}, ctrl.pol_lo, ctrl.en_lo);
      pwm_hi = level({{CW{1'b0}}, cnt_hi}, {{CW{1'b0}}, duty_act_hi}, ctrl.pol_hi, ctrl.en_hi);
    end
  end

  pwm_rd_port #(.CW(CW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .rd_wide(rd_wide),
    .rd_hi(rd_hi), .merge_on(merge_on), .cnt_wr(cnt_wr), .ctrl_bits(ctrl),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .per_lo(per_buf_lo), .per_hi(per_buf_hi),
    .duty_lo(duty_buf_lo), .duty_hi(duty_buf_hi), .rd_data(rd_data));

endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          merge_on,
  input logic          en_lo_b,
  input logic          pol_lo_b,
  input logic          cae_lo_b,
  input logic          pwm_lo,
  input logic          pwm_hi,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi,
  input logic [CW-1:0] per_act_lo,
  input logic          clr_lo,
  input logic          tick_lo,
  input logic          step_lo,
  input logic          ld_lo,
  input logic          rd_en,
  input logic [1:0]    rd_sel,
  input logic          rd_wide,
  input logic [2*CW-1:0] rd_data
);

  // R7: merged mode parks the high pin
  a_r7_hi_parked: assert property (@(posedge clk) disable iff (!rst_n)
    merge_on |-> !pwm_hi);

  // R6: a disabled low channel shows the inverse of its polarity
  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lo_b |-> (pwm_lo == !pol_lo_b));

  // R6: a disabled low channel does not count
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_lo_b && !clr_lo) |=> $stable(cnt_lo));

  // R4: no selected strobe, no movement
  a_r4_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!merge_on && en_lo_b && !tick_lo && !clr_lo) |=> $stable(cnt_lo));

  // R9: a counter write in merged mode clears both halves
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_on && clr_lo) |=> (cnt_lo == '0 && cnt_hi == '0));

  // R5: active period only changes on a load event
  a_r5_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_lo |=> $stable(per_act_lo));

  // R10: wide counter read returns both halves from one cycle
  a_r10_wide_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd1 && rd_wide) |=> (rd_data == {$past(cnt_hi), $past(cnt_lo)}));

  // R2: left-aligned counter climbs by one below the wrap point
  a_r2_left_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (step_lo && !cae_lo_b && per_act_lo > CW'(1) && cnt_lo < per_act_lo - CW'(1))
      |=> (cnt_lo == CW'($past(cnt_lo) + CW'(1))));

endmodule

bind pwm_pair_ctl pwm_pair_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .merge_on(merge_on), .en_lo_b(en_lo_b),
  .pol_lo_b(pol_lo_b), .cae_lo_b(cae_lo_b), .pwm_lo(pwm_lo), .pwm_hi(pwm_hi),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .per_act_lo(per_act_lo), .clr_lo(clr_lo),
  .tick_lo(tick_lo), .step_lo(step_lo), .ld_lo(ld_lo), .rd_en(rd_en),
  .rd_sel(rd_sel), .rd_wide(rd_wide), .rd_data(rd_data));

// File: tb/sim_pwm_pair_ctl.sv
module sim_pwm_pair_ctl;
  localparam int CW = 8;
  localparam int DW = 16;

  // control bit values (R12)
  localparam int EN_LO = 1, EN_HI = 2, POL_LO = 4, POL_HI = 8;
  localparam int CAE_LO = 16, CAE_HI = 32, CS_LO = 64, CS_HI = 128, MRG = 256;

  logic clk = 0, rst_n = 0, tick_a = 0, tick_b = 0;
  logic wr_en = 0, wr_wide = 0, wr_hi = 0, rd_en = 0, rd_wide = 0, rd_hi = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic pwm_lo, pwm_hi;

  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  pwm_pair_ctl #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_wide(wr_wide), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_wide(rd_wide), .rd_hi(rd_hi), .rd_data(rd_data),
    .pwm_lo(pwm_lo), .pwm_hi(pwm_hi));

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input bit wide, input bit hi, input int d);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_wide = wide; wr_hi = hi; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int sel, input bit wide, input bit hi, output int q);
    @(negedge clk);
    rd_en = 1; rd_sel = 2'(sel); rd_wide = wide; rd_hi = hi;
    @(negedge clk);
    rd_en = 0;
    q = int'(rd_data);
  endtask

  task automatic pulse(input bit use_b);
    @(negedge clk);
    tick_a = !use_b; tick_b = use_b;
    @(negedge clk);
    tick_a = 0; tick_b = 0;
  endtask

  function automatic int exp_cnt(input int k, input int per, input bit center);
    int ph;
    if (per == 0) return 0;
    if (!center) return k % per;
    ph = k % (2 * per);
    return (ph <= per) ? ph : 2 * per - ph;
  endfunction

  function automatic int exp_lvl(input int c, input int d, input bit pol);
    return (c < d) ? int'(pol) : int'(!pol);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int q;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 pwm_lo", pwm_lo, 1);
    chk("R1 pwm_hi", pwm_hi, 1);
    rd(0, 1, 0, q); chk("R1 ctrl", q, 0);
    rd(1, 1, 0, q); chk("R1 cnt", q, 0);
    rd(2, 1, 0, q); chk("R1 per", q, 0);

    // R2 / R3 sweep on the low channel in split mode
    for (int cen = 0; cen < 2; cen++)
      for (int per = 1; per <= 5; per++)
        for (int duty = 0; duty <= per + 1; duty++) begin
          bit pol;
          pol = 1'((per + duty) % 2);
          wr(0, 1, 0, 0);
          wr(2, 0, 0, per);
          wr(3, 0, 0, duty);
          wr(1, 0, 0, 0);
          wr(0, 1, 0, EN_LO | (pol ? POL_LO : 0) | (cen ? CAE_LO : 0));
          chk(cen ? "R3 start level" : "R2 start level", pwm_lo, exp_lvl(0, duty, pol));
          for (int k = 1; k <= 2 * per + 1; k++) begin
            pulse(0);
            chk(cen ? "R3 level" : "R2 level", pwm_lo,
                exp_lvl(exp_cnt(k, per, 1'(cen)), duty, pol));
            rd(1, 0, 0, q);
            chk(cen ? "R3 count" : "R2 count", q, exp_cnt(k, per, 1'(cen)));
          end
          chk("R6 idle hi pin", pwm_hi, 1);
        end

    // R4 high channel on strobe B, strobe A ignored; low channel off
    wr(0, 1, 0, 0);
    wr(2, 0, 1, 3);
    wr(3, 0, 1, 1);
    wr(1, 0, 1, 0);
    wr(0, 1, 0, EN_HI | POL_HI | CS_HI);
    for (int k = 1; k <= 7; k++) begin
      pulse(0);
      rd(1, 0, 1, q);
      chk("R4 strobe A ignored", q, exp_cnt(k - 1, 3, 0));
      pulse(1);
      chk("R4 hi level", pwm_hi, exp_lvl(exp_cnt(k, 3, 0), 1, 1));
      rd(1, 0, 1, q);
      chk("R4 hi count", q, exp_cnt(k, 3, 0));
    end

    // R5 buffered period/duty on the low channel
    wr(0, 1, 0, 0);
    wr(2, 0, 0, 4);
    wr(3, 0, 0, 2);
    wr(1, 0, 0, 0);
    wr(0, 1, 0, EN_LO | POL_LO);
    pulse(0);
    wr(2, 0, 0, 6);
    wr(3, 0, 0, 5);
    rd(2, 0, 0, q); chk("R5 buffer readback", q, 6);
    for (int i = 0; i < 9; i++) begin
      int c, d;
      c = (i < 2) ? 2 + i : (i - 2) % 6;
      d = (i < 2) ? 2 : 5;
      pulse(0);
      rd(1, 0, 0, q);
      chk("R5 count", q, c);
      chk("R5 level", pwm_lo, exp_lvl(c, d, 1));
    end

    // R6 disable holds the counter, pin goes to inverse polarity
    rd(1, 0, 0, q);
    begin
      int held;
      held = q;
      wr(0, 1, 0, POL_LO);
      chk("R6 off level", pwm_lo, 0);
      pulse(0); pulse(1);
      rd(1, 0, 0, q);
      chk("R6 held count", q, held);
    end

    // R7 / R8 / R10 merged left-aligned, high bits set to conflicting values
    wr(0, 1, 0, MRG);
    wr(2, 1, 0, 16'h0102);
    wr(3, 1, 0, 16'h0100);
    wr(1, 1, 0, 0);
    wr(0, 1, 0, MRG | EN_LO | POL_HI | CAE_HI | CS_HI);
    for (int k = 1; k <= 300; k++) begin
      pulse(0);
      chk("R7 merged level", pwm_lo, exp_lvl(k % 258, 16'h0100, 0));
      chk("R7 hi parked", pwm_hi, 0);
      rd(1, 1, 0, q);
      chk("R10 wide count", q, k % 258);
    end
    pulse(1); pulse(1);
    rd(1, 1, 0, q);
    chk("R8 hi clock-select ignored", q, 300 % 258);

    // R8 merged center-aligned: low alignment and polarity used, high enable ignored
    wr(0, 1, 0, MRG | EN_HI);
    chk("R8 hi enable ignored", pwm_hi, 0);
    wr(2, 1, 0, 16'h0101);
    wr(3, 1, 0, 16'h0081);
    wr(1, 1, 0, 0);
    wr(0, 1, 0, MRG | EN_LO | CAE_LO | POL_LO | EN_HI);
    for (int k = 1; k <= 520; k++) begin
      pulse(0);
      chk("R8 center level", pwm_lo, exp_lvl(exp_cnt(k, 257, 1), 16'h0081, 1));
      rd(1, 1, 0, q);
      chk("R3 merged center count", q, exp_cnt(k, 257, 1));
    end

    // R9 counter writes clear the merged counter
    wr(1, 0, 1, 16'h00AA);
    rd(1, 1, 0, q); chk("R9 merged hi byte clear", q, 0);
    for (int k = 0; k < 5; k++) pulse(0);
    rd(1, 1, 0, q); chk("R9 count after clear", q, 5);
    wr(1, 0, 0, 16'h0055);
    rd(1, 1, 0, q); chk("R9 merged lo byte clear", q, 0);

    // R9 split mode: only the addressed channel clears
    wr(0, 1, 0, 0);
    wr(2, 1, 0, 16'hC8C8);
    wr(1, 1, 0, 0);
    wr(0, 1, 0, EN_LO | EN_HI);
    for (int k = 0; k < 10; k++) pulse(0);
    rd(1, 1, 0, q); chk("R9 split count", q, 16'h0A0A);
    wr(1, 0, 1, 16'h0077);
    rd(1, 1, 0, q); chk("R9 split hi only", q, 16'h000A);

    // R11 byte-read coherency in merged mode
    wr(0, 1, 0, MRG);
    wr(2, 1, 0, 16'h0200);
    wr(3, 1, 0, 0);
    wr(1, 1, 0, 0);
    wr(0, 1, 0, MRG | EN_LO);
    for (int k = 0; k < 255; k++) pulse(0);
    rd(1, 0, 0, q); chk("R11 lo live", q, 16'h00FF);
    pulse(0);
    rd(1, 0, 1, q); chk("R11 hi latched", q, 16'h0000);
    rd(1, 0, 1, q); chk("R11 hi live", q, 16'h0001);
    pulse(0);
    rd(1, 0, 0, q); chk("R11 lo latched", q, 16'h0000);
    rd(1, 0, 0, q); chk("R11 lo live again", q, 16'h0001);

    // R12 register map readback
    wr(0, 1, 0, MRG | CS_LO | CAE_HI | POL_LO);
    rd(0, 1, 0, q); chk("R12 ctrl readback", q, MRG | CS_LO | CAE_HI | POL_LO);
    wr(3, 1, 0, 16'hA55A);
    rd(3, 0, 1, q); chk("R12 duty hi byte", q, 16'h00A5);
    rd(3, 0, 0, q); chk("R12 duty lo byte", q, 16'h005A);
    wr(2, 0, 1, 16'h0033);
    rd(2, 1, 0, q); chk("R12 period wide", q, 16'h3300);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule